// File: doc/BRIEF.md
# Miss-Dependent Instruction Deferral Buffer

This block sits between decode and execute. It lets the pipeline keep issuing while one long-latency load is outstanding. When the load misses, the caller announces the load's destination tag on the miss-start port. From then on, every decoded instruction is classified before it reaches execute. An instruction that touches the missing tag, or touches the destination of an instruction already parked, is parked in an in-order deferral FIFO. An instruction that touches neither goes straight to execute. A parked instruction therefore holds no issue slot while the miss is outstanding.

When the caller reports on the miss-done port that the load has returned, the parked instructions replay to execute one per cycle, in the order they were accepted. Only the parked instructions replay; work that already went to execute is never repeated. Each destination of a parked instruction counts as pending until that instruction drains. Later readers and writers of that tag are therefore parked behind it, including instructions that arrive while the drain is under way. The block has a single execute port, so a replay takes priority over a newly decoded independent instruction.

Top module: `miss_defer_buf`

## Requirements
- R1: After reset, `ex_valid` is low, `dec_ready` is high and no tag is pending.
- R2: An accepted instruction that does not depend on the miss or on a parked instruction is presented on the execute port exactly one cycle after acceptance. Its opcode and tags are unchanged and `ex_replay` is 0.
- R3: At most one miss is outstanding. A miss-start takes effect from the cycle after it is asserted. While the miss is outstanding, an instruction whose first source, second source or destination equals the miss tag is parked, and no parked instruction reaches execute.
- R4: An instruction whose first source, second source or destination equals the destination of any instruction still parked is itself parked, even when it does not touch the miss tag directly.
- R5: From the cycle after miss-done, the parked instructions leave one per cycle, in acceptance order, each with `ex_replay` = 1, one cycle after it leaves the buffer.
- R6: Every accepted instruction appears on the execute port exactly once.
- R7: While the buffer holds DEPTH entries, `dec_ready` is low and no instruction is accepted.
- R8: An instruction that arrives during the drain and touches a still-pending tag is parked behind the entries that are still draining.
- R9: In a cycle in which a parked instruction leaves the buffer, an incoming independent instruction is held off (`dec_ready` low).
- R10: A parked instruction's destination stops being pending when that instruction drains, so a later reader of that tag goes directly to execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | Decoded instruction present |
| dec_src0 | input | TAG_W | First source tag |
| dec_src1 | input | TAG_W | Second source tag |
| dec_dst | input | TAG_W | Destination tag |
| dec_op | input | OP_W | Opcode and payload, carried unchanged |
| dec_ready | output | 1 | Instruction accepted at this edge when high with dec_valid |
| miss_start | input | 1 | A load missed; its destination is miss_tag |
| miss_tag | input | TAG_W | Destination tag of the missing load |
| miss_done | input | 1 | The outstanding miss has returned |
| ex_valid | output | 1 | Instruction issued to execute |
| ex_replay | output | 1 | Issued instruction came from the deferral buffer |
| ex_src0 | output | TAG_W | First source tag of issued instruction |
| ex_src1 | output | TAG_W | Second source tag of issued instruction |
| ex_dst | output | TAG_W | Destination tag of issued instruction |
| ex_op | output | OP_W | Opcode and payload of issued instruction |

## Verification
The bench uses the default build: 4-bit tags (16 registers), a four-entry buffer and an 8-bit opcode. With these sizes, every tag can be swept as the miss tag, and the buffer can be driven to its full boundary in a few instructions. Instructions arriving mid-drain exercise the arbitration between a replay and new work, and the chained and write-after-write parking cases across the whole tag space. Classification and drain order come from an arithmetic model of pending counts kept in the bench.

// File: rtl/dfb_pkg.sv
// Package: shared routing type for the deferral buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package dfb_pkg;

    // Where a decoded instruction is sent
    typedef enum logic {
        ROUTE_EXEC = 1'b0,
        ROUTE_PARK = 1'b1
    } route_e;

endpackage

// File: rtl/dfb_tag_track.sv
// Module: dfb_tag_track
// Holds the single outstanding miss tag and, per tag, a count of parked
// instructions that write it. It classifies the incoming instruction as
// parked or executable.
// Assumes: at most one miss outstanding; miss_done only while a miss is active.
module dfb_tag_track
    import dfb_pkg::*;
#(
    parameter int TAG_W = 4,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_start,
    input  logic [TAG_W-1:0] miss_tag,
    input  logic             miss_done,
    input  logic [TAG_W-1:0] src0,
    input  logic [TAG_W-1:0] src1,
    input  logic [TAG_W-1:0] dst,
    input  logic             push,
    input  logic [TAG_W-1:0] push_dst,
    input  logic             pop,
    input  logic [TAG_W-1:0] pop_dst,
    output route_e           route,
    output logic             miss_active,
    output logic             any_pending
);
    localparam int NTAGS = 1 << TAG_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [TAG_W-1:0] miss_tag_q;
    logic [NTAGS-1:0] busy;

    // Miss state: set on start, cleared on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_active <= 1'b0;
            miss_tag_q  <= '0;
        end else if (miss_start) begin
            miss_active <= 1'b1;
            miss_tag_q  <= miss_tag;
        end else if (miss_done) begin
            miss_active <= 1'b0;
        end
    end

    for (genvar t = 0; t < NTAGS; t++) begin : g_tag
        logic [CNT_W-1:0] cnt;
        logic             inc;
        logic             dcr;
        assign inc = push && (push_dst == TAG_W'(t));
        assign dcr = pop  && (pop_dst  == TAG_W'(t));

        // Count parked writers of this tag
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt <= '0;
            else if (inc && !dcr)
                cnt <= cnt + 1'b1;
            else if (dcr && !inc)
                cnt <= cnt - 1'b1;
        end

        assign busy[t] = (cnt != '0);

        // R10: a drain never releases a tag with no parked writer
        p_no_release_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            dcr && !inc |-> cnt != '0);
        // R4: pending count never wraps
        p_no_count_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            inc && !dcr |-> cnt != {CNT_W{1'b1}});
    end

    logic hit_miss;
    logic hit_park;

    // Classify the incoming instruction against miss and parked tags
    always_comb begin
        hit_miss = miss_active &&
                   (src0 == miss_tag_q || src1 == miss_tag_q || dst == miss_tag_q);
        hit_park = busy[src0] || busy[src1] || busy[dst];
        route    = (hit_miss || hit_park) ? ROUTE_PARK : ROUTE_EXEC;
    end

    assign any_pending = |busy;

    // R3: only one miss at a time
    p_single_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_start |-> !miss_active);
    // R3: completion only for an outstanding miss
    p_done_when_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_done |-> miss_active);

endmodule

// File: rtl/dfb_fifo.sv
// Module: dfb_fifo
// In-order storage for parked instructions: a circular buffer with a
// registered occupancy count. Pushing while full and popping while empty
// are caller errors.
module dfb_fifo #(
    parameter int W     = 20,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;

    // Next slot after p, wrapping at DEPTH
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store a pushed entry
    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= wdata;
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)
                count <= count + 1'b1;
            else if (pop && !push)
                count <= count - 1'b1;
        end
    end

    assign rdata = mem[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // R7: never store into a full buffer
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R5: never drain an empty buffer
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R7: occupancy bounded by depth
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

// File: rtl/dfb_issue_reg.sv
// Module: dfb_issue_reg
// Registered execute port. A drained entry wins over a forwarded one; the
// caller guarantees the two never coincide.
module dfb_issue_reg #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pop,
    input  logic [W-1:0] pop_data,
    input  logic         fwd,
    input  logic [W-1:0] fwd_data,
    output logic         ex_valid,
    output logic         ex_replay,
    output logic [W-1:0] ex_data
);
    // Capture the instruction issued this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_valid  <= 1'b0;
            ex_replay <= 1'b0;
            ex_data   <= '0;
        end else if (pop) begin
            ex_valid  <= 1'b1;
            ex_replay <= 1'b1;
            ex_data   <= pop_data;
        end else if (fwd) begin
            ex_valid  <= 1'b1;
            ex_replay <= 1'b0;
            ex_data   <= fwd_data;
        end else begin
            ex_valid  <= 1'b0;
            ex_replay <= 1'b0;
        end
    end

    // R9: single execute port, never two sources in one cycle
    p_one_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && fwd));

endmodule

// File: rtl/miss_defer_buf.sv
// Module: miss_defer_buf (top)
// Routes decoded instructions either straight to execute or into an in-order
// deferral buffer, depending on the outstanding miss and on already parked
// destinations. After the miss completes, it drains the buffer one entry
// per cycle.
// Assumes: execute always accepts; one miss outstanding at a time.
module miss_defer_buf
    import dfb_pkg::*;
#(
    parameter int TAG_W = 4,
    parameter int OP_W  = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [TAG_W-1:0] dec_src0,
    input  logic [TAG_W-1:0] dec_src1,
    input  logic [TAG_W-1:0] dec_dst,
    input  logic [OP_W-1:0]  dec_op,
    output logic             dec_ready,
    input  logic             miss_start,
    input  logic [TAG_W-1:0] miss_tag,
    input  logic             miss_done,
    output logic             ex_valid,
    output logic             ex_replay,
    output logic [TAG_W-1:0] ex_src0,
    output logic [TAG_W-1:0] ex_src1,
    output logic [TAG_W-1:0] ex_dst,
    output logic [OP_W-1:0]  ex_op
);
    localparam int IW = OP_W + 3 * TAG_W;

    route_e        route;
    logic          miss_active;
    logic          any_pending;
    logic          full;
    logic          empty;
    logic          pop;
    logic          push;
    logic          fwd;
    logic          accept;
    logic [IW-1:0] dec_word;
    logic [IW-1:0] head_word;
    logic [IW-1:0] ex_word;

    assign dec_word = {dec_op, dec_dst, dec_src1, dec_src0};

    // Drain whenever entries wait and no miss is outstanding
    always_comb begin
        pop       = !empty && !miss_active;
        dec_ready = !full && !(pop && route == ROUTE_EXEC);
        accept    = dec_valid && dec_ready;
        push      = accept && route == ROUTE_PARK;
        fwd       = accept && route == ROUTE_EXEC;
    end

    dfb_tag_track #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_start  (miss_start),
        .miss_tag    (miss_tag),
        .miss_done   (miss_done),
        .src0        (dec_src0),
        .src1        (dec_src1),
        .dst         (dec_dst),
        .push        (push),
        .push_dst    (dec_dst),
        .pop         (pop),
        .pop_dst     (head_word[3*TAG_W-1:2*TAG_W]),
        .route       (route),
        .miss_active (miss_active),
        .any_pending (any_pending)
    );

    dfb_fifo #(.W(IW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (dec_word),
        .pop   (pop),
        .rdata (head_word),
        .full  (full),
        .empty (empty)
    );

    dfb_issue_reg #(.W(IW)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (pop),
        .pop_data  (head_word),
        .fwd       (fwd),
        .fwd_data  (dec_word),
        .ex_valid  (ex_valid),
        .ex_replay (ex_replay),
        .ex_data   (ex_word)
    );

    assign {ex_op, ex_dst, ex_src1, ex_src0} = ex_word;

    // R3: nothing parked reaches execute while the miss is outstanding
    p_miss_blocks_replay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_active |=> !(ex_valid && ex_replay));
    // R2: forwarded instruction appears next cycle as non-replay
    p_fwd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fwd |=> ex_valid && !ex_replay);
    // R5: drained entry appears next cycle as replay
    p_drain_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> ex_valid && ex_replay);
    // R7: full buffer holds off decode
    p_full_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !dec_ready);
    // R10: empty buffer leaves no tag pending
    p_empty_no_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !any_pending);

endmodule

// File: tb/miss_defer_buf_bench.sv
`timescale 1ns/1ps
module miss_defer_buf_bench;
    localparam int TAG_W = 4;
    localparam int OP_W  = 8;
    localparam int DEPTH = 4;
    localparam int NT    = 1 << TAG_W;
    localparam int IW    = OP_W + 3 * TAG_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 1'b0;
    logic [TAG_W-1:0] dec_src0 = '0, dec_src1 = '0, dec_dst = '0;
    logic [OP_W-1:0]  dec_op = '0;
    logic dec_ready;
    logic miss_start = 1'b0;
    logic [TAG_W-1:0] miss_tag = '0;
    logic miss_done = 1'b0;
    logic ex_valid, ex_replay;
    logic [TAG_W-1:0] ex_src0, ex_src1, ex_dst;
    logic [OP_W-1:0]  ex_op;

    always #2.5 clk = ~clk;

    miss_defer_buf #(.TAG_W(TAG_W), .OP_W(OP_W), .DEPTH(DEPTH)) u_miss_defer_buf (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_src0(dec_src0), .dec_src1(dec_src1),
        .dec_dst(dec_dst), .dec_op(dec_op), .dec_ready(dec_ready),
        .miss_start(miss_start), .miss_tag(miss_tag), .miss_done(miss_done),
        .ex_valid(ex_valid), .ex_replay(ex_replay), .ex_src0(ex_src0),
        .ex_src1(ex_src1), .ex_dst(ex_dst), .ex_op(ex_op)
    );

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    // Bench model state
    bit               m_miss = 1'b0;
    logic [TAG_W-1:0] m_tag = '0;
    int               m_cnt [NT];
    logic [IW-1:0]    park_q [$];
    bit               fwd_pend = 1'b0;
    logic [IW-1:0]    fwd_exp = '0;
    logic [OP_W-1:0]  next_op = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_dep(input logic [TAG_W-1:0] s0, s1, d);
        bit hm;
        hm = m_miss && (s0 == m_tag || s1 == m_tag || d == m_tag);
        return hm || m_cnt[s0] != 0 || m_cnt[s1] != 0 || m_cnt[d] != 0;
    endfunction

    // Monitor: compares every execute-port output with the model
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (fwd_pend) begin
                check(ex_valid && !ex_replay && {ex_op, ex_dst, ex_src1, ex_src0} == fwd_exp,
                      "R2", "forwarded instruction", {ex_valid, ex_replay, ex_op, ex_dst, ex_src1, ex_src0},
                      {2'b10, fwd_exp});
                fwd_pend = 1'b0;
            end else if (ex_valid && !ex_replay) begin
                check(1'b0, "R6", "unexpected direct issue", {ex_op, ex_dst}, 0);
            end else if (ex_valid && ex_replay) begin
                check(!m_miss, "R3", "replay while miss outstanding", 1, 0);
                if (park_q.size() == 0) begin
                    check(1'b0, "R6", "replay with nothing parked", {ex_op, ex_dst}, 0);
                end else begin
                    check({ex_op, ex_dst, ex_src1, ex_src0} == park_q[0], "R5",
                          "replay order", {ex_op, ex_dst, ex_src1, ex_src0}, park_q[0]);
                    m_cnt[park_q[0][3*TAG_W-1:2*TAG_W]]--;
                    void'(park_q.pop_front());
                end
            end
        end
    end

    task automatic issue(input logic [TAG_W-1:0] s0, s1, d);
        int guard;
        @(negedge clk);
        dec_valid = 1'b1; dec_src0 = s0; dec_src1 = s1; dec_dst = d; dec_op = next_op;
        next_op++;
        #1;
        guard = 0;
        while (!dec_ready && guard < 60) begin
            @(negedge clk); #1; guard++;
        end
        if (guard >= 60) begin
            check(1'b0, "R7", "decode never accepted", 0, 1);
            dec_valid = 1'b0;
        end else begin
            @(posedge clk);
            if (m_dep(s0, s1, d)) begin
                park_q.push_back({dec_op, d, s1, s0});
                m_cnt[d]++;
            end else begin
                fwd_pend = 1'b1;
                fwd_exp  = {dec_op, d, s1, s0};
            end
            #1 dec_valid = 1'b0;
        end
    endtask

    task automatic miss_begin(input logic [TAG_W-1:0] t);
        @(negedge clk);
        miss_start = 1'b1; miss_tag = t;
        @(posedge clk);
        m_miss = 1'b1; m_tag = t;
        @(negedge clk);
        miss_start = 1'b0;
    endtask

    task automatic miss_end();
        @(negedge clk);
        miss_done = 1'b1;
        @(posedge clk);
        m_miss = 1'b0;
        @(negedge clk);
        miss_done = 1'b0;
    endtask

    task automatic wait_drain();
        int guard;
        guard = 0;
        while ((park_q.size() != 0 || fwd_pend) && guard < 100) begin
            @(negedge clk); guard++;
        end
        check(guard < 100, "R5", "drain completes", park_q.size(), 0);
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NT; i++) m_cnt[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!ex_valid, "R1", "ex_valid in reset", ex_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!ex_valid && dec_ready, "R1", "state after reset", {ex_valid, dec_ready}, 2'b01);

        // R2: independent sweep, no miss
        for (int t = 0; t < NT; t++) issue(t[3:0], 4'(t + 1), t[3:0]);
        wait_drain();

        // R3 R4 R10: miss on tag 3, chain and write-after-write
        miss_begin(4'd3);
        issue(4'd3, 4'd0, 4'd5);   // reads miss tag: parked (R3)
        issue(4'd1, 4'd1, 4'd2);   // independent: executes (R2)
        issue(4'd5, 4'd1, 4'd6);   // reads parked dst 5: parked (R4)
        issue(4'd0, 4'd0, 4'd3);   // writes miss tag: parked (R3)
        issue(4'd7, 4'd8, 4'd6);   // writes parked dst 6: parked (R4)
        repeat (4) @(negedge clk);
        check(park_q.size() == 4, "R3", "entries held during miss", park_q.size(), 4);
        miss_end();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(ex_valid && ex_replay, "R5", "one replay per cycle", {ex_valid, ex_replay}, 2'b11);
        end
        wait_drain();
        issue(4'd6, 4'd5, 4'd9);   // tags released: executes directly (R10)
        wait_drain();

        // R7: full buffer stalls decode
        miss_begin(4'd7);
        for (int k = 0; k < DEPTH; k++) issue(4'd7, 4'd7, 4'(8 + k));
        @(negedge clk);
        dec_valid = 1'b1; dec_src0 = 4'd7; dec_src1 = 4'd0; dec_dst = 4'd1; dec_op = 8'hEE;
        #1 check(!dec_ready, "R7", "ready low when full", dec_ready, 0);
        @(negedge clk); #1;
        check(!dec_ready, "R7", "ready stays low when full", dec_ready, 0);
        dec_valid = 1'b0;
        miss_end();
        wait_drain();

        // R8 R9: arrivals during drain
        miss_begin(4'd8);
        for (int k = 0; k < DEPTH; k++) issue(4'd8, 4'd0, 4'(9 + k));
        miss_end();
        dec_valid = 1'b1; dec_src0 = 4'd1; dec_src1 = 4'd2; dec_dst = 4'd3; dec_op = 8'hDD;
        #1 check(!dec_ready, "R9", "independent held during replay", dec_ready, 0);
        dec_valid = 1'b0;
        issue(4'd12, 4'd1, 4'd13);  // reads pending 12: appended behind (R8)
        issue(4'd1, 4'd2, 4'd4);    // independent, waits for port (R9)
        wait_drain();
        check(park_q.size() == 0, "R8", "appended entry drained", park_q.size(), 0);

        // Sweep: every tag as miss tag, mixed dependence patterns
        for (int m = 0; m < NT; m++) begin
            miss_begin(4'(m));
            for (int i = 0; i < 6; i++)
                issue(4'((i == 0) ? m : m + i * 5), 4'(m * 3 + i * 7), 4'(m + i + 1));
            miss_end();
            issue(4'(m + 1), 4'(m + 9), 4'(m + 14));
            issue(4'(m + 2), 4'(m + 2), 4'(m + 5));
            wait_drain();
        end

        // R6: everything issued exactly once
        check(park_q.size() == 0 && !fwd_pend, "R6", "all instructions issued", park_q.size(), 0);
        done_flag = 1'b1;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule